// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns CPU-side request addresses into bus-side addresses through a small, parameterised set of outbound windows. Each window holds a base, an inclusive last address, a 64-bit target, a transaction kind and an enable bit. A request that falls inside an enabled window leaves one cycle later with the window's target plus the request's distance from the window base, together with the window's kind and a hit flag. A request that misses every window leaves unchanged, with the hit flag low.

Software reaches all the windows through one shared register window. A selector register picks a direction and a window index, and the seven window registers then act on that window only. Windows of a configuration kind keep the bus, device and function number in the upper half of the low target word, so the request offset can never carry into those fields. The register read path is combinational. A write is visible on the read path from the next cycle, so software can write the enable register and read it back to make sure the window is active before it sends traffic.

Top module: `xw_translator`

## Requirements
- R1: After reset every window is disabled and the selector reads 0. xl_valid is low in every cycle that does not follow a cycle with req_valid high, and high in every cycle that does.
- R2: The selector register at offset 0x900 keeps bit 31 (direction, 1 = inbound) and bits 7:0 (window index). A read returns only those bits; all other bits read 0.
- R3: When the selector names an outbound window that exists, the registers at 0x904 (kind, bits 4:0), 0x908 (enable, bit 31), 0x90C/0x910 (base low/high), 0x914 (last address, low 32 bits) and 0x918/0x91C (target low/high) write and read back that window. Bits that are not stored read 0.
- R4: When the selector names the inbound direction or an index of NREG or more, writes to the window registers change no window and reads of them return 0.
- R5: A read of any offset other than the eight listed in R2 and R3 returns 0.
- R6: A request hits a window when the window is enabled, req_addr[63:32] equals the base high word, and base low <= req_addr[31:0] <= last address. Both bounds are inclusive. On a hit the next cycle shows xl_hit=1, the window's kind on xl_kind, and xl_addr = target + (req_addr[31:0] - base low), taken modulo 2^64.
- R7: When more than one window hits, the window with the lowest index supplies the result.
- R8: A request that hits no window produces xl_hit=0, xl_kind=0 and xl_addr equal to req_addr in the next cycle.
- R9: For kind 4 (type-0 configuration) and kind 5 (type-1 configuration), xl_addr[63:16] equals the target bits 63:16 (bus in bits 31:24, device in bits 23:19, function in bits 18:16). xl_addr[15:0] equals the target's low 16 bits plus the offset's low 16 bits, modulo 2^16. Kinds 0 (memory) and 2 (I/O) use the full addition of R6.
- R10: A register write and a request in the same cycle: the request is translated with the window settings as they were before that write.
- R11: A disabled window never hits. After a write of 1 to enable bit 31, a read of 0x908 in the next cycle returns 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | CPU-side request address |
| xl_valid | output | 1 | Result valid, one cycle after req_valid |
| xl_hit | output | 1 | Request matched a window |
| xl_addr | output | 64 | Translated, or passed-through, address |
| xl_kind | output | 5 | Kind of the matching window, 0 on a miss |

## Verification
A register write and a translation lookup can land in the same cycle. This matters most when the write enables or moves the very window that the request falls in. The bench provokes this directly: on one clock edge it asserts the enable write for a window and a request inside that window. It expects a miss, because the old settings apply, and then a hit from an identical request on the following edge. It also retargets a live window in the same cycle as a request and expects the old target. The random phase reprograms windows between request bursts, and the bench model applies each write only after the edge that commits it.

// File: rtl/xw_pkg.sv
package xw_pkg;

  localparam int REG_AW = 12;

  // Register offsets; software programs windows at these positions.
  localparam logic [REG_AW-1:0] OFS_VIEW   = 12'h900;
  localparam logic [REG_AW-1:0] OFS_KIND   = 12'h904;
  localparam logic [REG_AW-1:0] OFS_EN     = 12'h908;
  localparam logic [REG_AW-1:0] OFS_BASE_L = 12'h90C;
  localparam logic [REG_AW-1:0] OFS_BASE_H = 12'h910;
  localparam logic [REG_AW-1:0] OFS_LAST   = 12'h914;
  localparam logic [REG_AW-1:0] OFS_TGT_L  = 12'h918;
  localparam logic [REG_AW-1:0] OFS_TGT_H  = 12'h91C;

  localparam logic [4:0] KIND_MEM  = 5'd0;
  localparam logic [4:0] KIND_IO   = 5'd2;
  localparam logic [4:0] KIND_CFG0 = 5'd4;
  localparam logic [4:0] KIND_CFG1 = 5'd5;

  typedef struct packed {
    logic        en;
    logic [4:0]  kind;
    logic [31:0] base_lo;
    logic [31:0] base_hi;
    logic [31:0] last;
    logic [31:0] tgt_lo;
    logic [31:0] tgt_hi;
  } xw_region_t;

  // Inclusive window match; only the low word takes part in the range test.
  function automatic logic in_window(input xw_region_t r, input logic [63:0] a);
    return r.en && (a[63:32] == r.base_hi) &&
           (a[31:0] >= r.base_lo) && (a[31:0] <= r.last);
  endfunction

  // Target plus offset; configuration kinds keep bus/device/function intact.
  function automatic logic [63:0] map_addr(input xw_region_t r, input logic [63:0] a);
    logic [31:0] off;
    off = a[31:0] - r.base_lo;
    if (r.kind == KIND_CFG0 || r.kind == KIND_CFG1)
      return {r.tgt_hi, r.tgt_lo[31:16], r.tgt_lo[15:0] + off[15:0]};
    return {r.tgt_hi, r.tgt_lo} + {32'b0, off};
  endfunction

endpackage

// File: rtl/xw_viewport.sv
module xw_viewport
  import xw_pkg::*;
#(
  parameter int NREG = 2,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_dir,
  input  logic [7:0]        wr_idx,
  output logic [31:0]       view_word,
  output logic              sel_ok,
  output logic [IW-1:0]     sel_idx
);
  logic       dir_q;
  logic [7:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      idx_q <= '0;
    end else if (wr_en) begin
      dir_q <= wr_dir;
      idx_q <= wr_idx;
    end
  end

  assign view_word = {dir_q, 23'b0, idx_q};
  assign sel_ok    = !dir_q && (int'(idx_q) < NREG);
  assign sel_idx   = idx_q[IW-1:0];
endmodule

// File: rtl/xw_region_bank.sv
module xw_region_bank
  import xw_pkg::*;
#(
  parameter int NREG = 2,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_ofs,
  input  logic [31:0]       wr_data,
  input  logic              sel_ok,
  input  logic [IW-1:0]     sel_idx,
  output xw_region_t        regs_o [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_win
    xw_region_t r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (wr_en && sel_ok && (sel_idx == IW'(g))) begin
        case (wr_ofs)
          OFS_KIND:   r_q.kind    <= wr_data[4:0];
          OFS_EN:     r_q.en      <= wr_data[31];
          OFS_BASE_L: r_q.base_lo <= wr_data;
          OFS_BASE_H: r_q.base_hi <= wr_data;
          OFS_LAST:   r_q.last    <= wr_data;
          OFS_TGT_L:  r_q.tgt_lo  <= wr_data;
          OFS_TGT_H:  r_q.tgt_hi  <= wr_data;
          default: ;
        endcase
      end
    end
    assign regs_o[g] = r_q;
  end
endmodule

// File: rtl/xw_pick.sv
module xw_pick
  import xw_pkg::*;
#(
  parameter int NREG = 2,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  xw_region_t        regs_i [NREG],
  input  logic [63:0]       req_addr,
  output logic [NREG-1:0]   raw_hit,
  output logic [NREG-1:0]   win_hot,
  output logic [IW-1:0]     win_idx,
  output logic              any_hit
);
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign raw_hit[g] = in_window(regs_i[g], req_addr);
  end

  // Scan from the top down so the lowest hitting index is written last.
  always_comb begin
    win_hot = '0;
    win_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (raw_hit[i]) begin
        win_hot    = '0;
        win_hot[i] = 1'b1;
        win_idx    = IW'(i);
      end
    end
  end

  assign any_hit = |raw_hit;
endmodule

// File: rtl/xw_translator.sv
module xw_translator
  import xw_pkg::*;
#(
  parameter int NREG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              xl_valid,
  output logic              xl_hit,
  output logic [63:0]       xl_addr,
  output logic [4:0]        xl_kind
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  xw_region_t        regs_w [NREG];
  logic [31:0]       view_word;
  logic              sel_ok;
  logic [IW-1:0]     sel_idx;
  logic [NREG-1:0]   raw_hit;
  logic [NREG-1:0]   win_hot;
  logic [IW-1:0]     win_idx;
  logic              any_hit;
  logic              view_we;
  xw_region_t        cur;
  xw_region_t        win;

  assign view_we = reg_we && (reg_addr == OFS_VIEW);

  xw_viewport #(.NREG(NREG)) u_view (
    .clk(clk), .rst_n(rst_n), .wr_en(view_we),
    .wr_dir(reg_wdata[31]), .wr_idx(reg_wdata[7:0]),
    .view_word(view_word), .sel_ok(sel_ok), .sel_idx(sel_idx)
  );

  xw_region_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .wr_ofs(reg_addr),
    .wr_data(reg_wdata), .sel_ok(sel_ok), .sel_idx(sel_idx), .regs_o(regs_w)
  );

  xw_pick #(.NREG(NREG)) u_pick (
    .regs_i(regs_w), .req_addr(req_addr), .raw_hit(raw_hit),
    .win_hot(win_hot), .win_idx(win_idx), .any_hit(any_hit)
  );

  assign cur = sel_ok ? regs_w[sel_idx] : '0;
  assign win = regs_w[win_idx];

  always_comb begin
    case (reg_addr)
      OFS_VIEW:   reg_rdata = view_word;
      OFS_KIND:   reg_rdata = {27'b0, cur.kind};
      OFS_EN:     reg_rdata = {cur.en, 31'b0};
      OFS_BASE_L: reg_rdata = cur.base_lo;
      OFS_BASE_H: reg_rdata = cur.base_hi;
      OFS_LAST:   reg_rdata = cur.last;
      OFS_TGT_L:  reg_rdata = cur.tgt_lo;
      OFS_TGT_H:  reg_rdata = cur.tgt_hi;
      default:    reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid <= 1'b0;
      xl_hit   <= 1'b0;
      xl_addr  <= '0;
      xl_kind  <= '0;
    end else begin
      xl_valid <= req_valid;
      xl_hit   <= req_valid && any_hit;
      if (req_valid) begin
        xl_addr <= any_hit ? map_addr(win, req_addr) : req_addr;
        xl_kind <= any_hit ? win.kind : KIND_MEM;
      end
    end
  end
endmodule

// File: rtl/xw_translator_chk.sv
module xw_translator_chk #(
  parameter int NREG = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [63:0]       req_addr,
  input logic              xl_valid,
  input logic              xl_hit,
  input logic [63:0]       xl_addr,
  input logic [NREG-1:0]   raw_hit,
  input logic [NREG-1:0]   win_hot,
  input logic [11:0]       reg_addr,
  input logic [31:0]       reg_rdata
);
  logic [NREG-1:0] below_win;
  logic            mapped;
  assign below_win = win_hot - NREG'(1);
  assign mapped = reg_addr inside {12'h900, 12'h904, 12'h908, 12'h90C,
                                   12'h910, 12'h914, 12'h918, 12'h91C};

  // R1: result valid follows request valid by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> xl_valid);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !xl_valid);

  // R5: unmapped offsets read zero
  a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> reg_rdata == 32'h0);

  // R6: any matching window gives a hit next cycle
  a_r6_hit_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (|raw_hit)) |=> xl_hit);

  // R7: exactly one winner, and no hitting window below it
  a_r7_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (|raw_hit) |-> $onehot(win_hot));
  a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|raw_hit) |-> ((below_win & raw_hit) == '0));

  // R8: a miss passes the address through untouched
  a_r8_miss_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(|raw_hit)) |=> (!xl_hit && xl_addr == $past(req_addr)));
endmodule

bind xw_translator xw_translator_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .xl_valid(xl_valid), .xl_hit(xl_hit), .xl_addr(xl_addr),
  .raw_hit(raw_hit), .win_hot(win_hot),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/tb_xw_translator.sv
module tb_xw_translator;
  localparam int NR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        xl_valid, xl_hit;
  logic [63:0] xl_addr;
  logic [4:0]  xl_kind;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xw_translator #(.NREG(NR)) dut (.*);

  // bench model
  bit          m_dir;
  logic [7:0]  m_idx;
  bit          m_en   [NR];
  logic [4:0]  m_kind [NR];
  logic [31:0] m_blo [NR], m_bhi [NR], m_last [NR], m_tlo [NR], m_thi [NR];

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic bit sel_live();
    return !m_dir && (int'(m_idx) < NR);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] ofs);
    int k;
    k = int'(m_idx);
    if (ofs == 12'h900) return {m_dir, 23'b0, m_idx};
    if (!sel_live()) return 32'h0;
    case (ofs)
      12'h904: return {27'b0, m_kind[k]};
      12'h908: return m_en[k] ? 32'h8000_0000 : 32'h0;
      12'h90C: return m_blo[k];
      12'h910: return m_bhi[k];
      12'h914: return m_last[k];
      12'h918: return m_tlo[k];
      12'h91C: return m_thi[k];
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input logic [11:0] ofs, input logic [31:0] d);
    int k;
    if (ofs == 12'h900) begin m_dir = d[31]; m_idx = d[7:0]; return; end
    if (!sel_live()) return;
    k = int'(m_idx);
    case (ofs)
      12'h904: m_kind[k] = d[4:0];
      12'h908: m_en[k]   = d[31];
      12'h90C: m_blo[k]  = d;
      12'h910: m_bhi[k]  = d;
      12'h914: m_last[k] = d;
      12'h918: m_tlo[k]  = d;
      12'h91C: m_thi[k]  = d;
      default: ;
    endcase
  endfunction

  // Expected translation: walk from the top so the lowest hit overwrites.
  function automatic void exp_xl(input logic [63:0] a, output bit h, output logic [63:0] o, output logic [4:0] kd);
    h = 0; o = a; kd = 5'd0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (m_en[i] && a[63:32] == m_bhi[i] && a[31:0] >= m_blo[i] && a[31:0] <= m_last[i]) begin
        logic [63:0] sum;
        sum = {m_thi[i], m_tlo[i]} + 64'(a[31:0] - m_blo[i]);
        if (m_kind[i] == 5'd4 || m_kind[i] == 5'd5)
          sum[63:16] = {m_thi[i], m_tlo[i][31:16]};
        h = 1; o = sum; kd = m_kind[i];
      end
    end
  endfunction

  task automatic wr(input logic [11:0] ofs, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = ofs; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
    model_write(ofs, d);
  endtask

  task automatic rd_chk(input logic [11:0] ofs, input string rq);
    logic [31:0] e;
    @(negedge clk);
    reg_addr = ofs; #1;
    e = exp_rd(ofs);
    chk(reg_rdata === e, rq, 128'(reg_rdata), 128'(e));
  endtask

  task automatic req_chk(input logic [63:0] a, input string rq);
    bit h; logic [63:0] o; logic [4:0] kd;
    @(negedge clk);
    req_valid = 1; req_addr = a;
    exp_xl(a, h, o, kd);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk(xl_valid === 1'b1 && xl_hit === h && xl_addr === o && xl_kind === kd, rq,
        {58'b0, xl_valid, xl_hit, xl_kind, xl_addr}, {58'b0, 1'b1, h, kd, o});
  endtask

  task automatic prog(input int k, input logic [4:0] kd, input bit en,
                      input logic [31:0] blo, input logic [31:0] bhi, input logic [31:0] last,
                      input logic [31:0] tlo, input logic [31:0] thi);
    wr(12'h900, 32'(k));
    wr(12'h904, 32'(kd));
    wr(12'h90C, blo); wr(12'h910, bhi); wr(12'h914, last);
    wr(12'h918, tlo); wr(12'h91C, thi);
    wr(12'h908, en ? 32'h8000_0000 : 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0042);
    m_dir = 0; m_idx = 0;
    for (int i = 0; i < NR; i++) begin
      m_en[i] = 0; m_kind[i] = 0; m_blo[i] = 0; m_bhi[i] = 0; m_last[i] = 0; m_tlo[i] = 0; m_thi[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd_chk(12'h900, "R1 selector after reset");
    rd_chk(12'h908, "R1 enable after reset");
    @(negedge clk);
    chk(xl_valid === 1'b0, "R1 no result without request", 128'(xl_valid), 128'(0));
    req_chk(64'h0, "R1 reset windows miss");

    // R2 selector
    wr(12'h900, 32'h8000_0003);
    rd_chk(12'h900, "R2 selector inbound idx3");
    wr(12'h900, 32'hFFFF_FF01);
    rd_chk(12'h900, "R2 selector stray bits dropped");

    // R4 inbound and out-of-range selections
    wr(12'h90C, 32'hDEAD_0000);
    rd_chk(12'h90C, "R4 inbound window reads zero");
    wr(12'h900, 32'h0000_0005);
    wr(12'h914, 32'h1234_5678);
    rd_chk(12'h914, "R4 out-of-range index reads zero");
    wr(12'h900, 32'h0000_0000);
    rd_chk(12'h90C, "R4 window 0 base untouched");
    wr(12'h900, 32'h0000_0001);
    rd_chk(12'h914, "R4 window 1 last untouched");

    // R5 unmapped offsets
    rd_chk(12'h920, "R5 offset 0x920");
    rd_chk(12'h000, "R5 offset 0x000");

    // R3 / R11 register access on window 0
    prog(0, 5'd2, 1, 32'h1000_0000, 32'h0, 32'h1000_FFFF, 32'hA000_0000, 32'h0000_0007);
    rd_chk(12'h908, "R11 enable readback after write");
    rd_chk(12'h904, "R3 kind readback");
    rd_chk(12'h90C, "R3 base low readback");
    rd_chk(12'h910, "R3 base high readback");
    rd_chk(12'h914, "R3 last readback");
    rd_chk(12'h918, "R3 target low readback");
    rd_chk(12'h91C, "R3 target high readback");
    wr(12'h904, 32'hFFFF_FFFF);
    rd_chk(12'h904, "R3 kind keeps bits 4:0");
    wr(12'h908, 32'hFFFF_FFFF);
    rd_chk(12'h908, "R11 enable keeps bit 31");
    wr(12'h904, 32'd2);

    // R6 / R8 inclusive bounds
    req_chk(64'h0000_0000_1000_0000, "R6 first address hits");
    req_chk(64'h0000_0000_1000_FFFF, "R6 last address hits");
    req_chk(64'h0000_0000_0FFF_FFFF, "R8 below base misses");
    req_chk(64'h0000_0000_1001_0000, "R8 above last misses");
    req_chk(64'h0000_0001_1000_0010, "R8 upper word mismatch misses");

    // R7 overlap
    prog(1, 5'd0, 1, 32'h1000_8000, 32'h0, 32'h1002_0000, 32'h5000_0000, 32'h0);
    req_chk(64'h0000_0000_1000_9000, "R7 lower index wins overlap");
    req_chk(64'h0000_0000_1001_0004, "R6 only window 1 hits");
    wr(12'h900, 32'h0);
    wr(12'h908, 32'h0);
    req_chk(64'h0000_0000_1000_9000, "R7 window 1 after window 0 off");
    req_chk(64'h0000_0000_1000_0100, "R11 disabled window misses");

    // R10 write and request in the same cycle
    @(negedge clk);
    reg_we = 1; reg_addr = 12'h908; reg_wdata = 32'h8000_0000;
    req_valid = 1; req_addr = 64'h0000_0000_1000_0100;
    begin
      bit h; logic [63:0] o; logic [4:0] kd;
      exp_xl(req_addr, h, o, kd);
      @(posedge clk); #1;
      reg_we = 0; req_valid = 0;
      model_write(12'h908, 32'h8000_0000);
      @(negedge clk);
      chk(xl_hit === h && xl_addr === o, "R10 enable same cycle uses old state",
          {63'b0, xl_hit, xl_addr}, {63'b0, h, o});
    end
    req_chk(64'h0000_0000_1000_0100, "R10 request after enable hits");
    @(negedge clk);
    reg_we = 1; reg_addr = 12'h918; reg_wdata = 32'hBBBB_0000;
    req_valid = 1; req_addr = 64'h0000_0000_1000_0200;
    begin
      bit h; logic [63:0] o; logic [4:0] kd;
      exp_xl(req_addr, h, o, kd);
      @(posedge clk); #1;
      reg_we = 0; req_valid = 0;
      model_write(12'h918, 32'hBBBB_0000);
      @(negedge clk);
      chk(xl_hit === h && xl_addr === o, "R10 retarget same cycle uses old target",
          {63'b0, xl_hit, xl_addr}, {63'b0, h, o});
    end

    // R9 configuration kinds
    prog(0, 5'd4, 1, 32'h4000_0000, 32'h0, 32'h4001_FFFF, 32'h12A3_FFF0, 32'h0);
    req_chk(64'h0000_0000_4001_0020, "R9 type-0 offset cannot carry into bus field");
    prog(1, 5'd5, 1, 32'h6000_0000, 32'h0, 32'h6000_0FFF, 32'h0708_0000, 32'h0);
    req_chk(64'h0000_0000_6000_0ABC, "R9 type-1 keeps bus/device/function");
    prog(1, 5'd0, 1, 32'h7000_0000, 32'h0, 32'h7001_FFFF, 32'h12A3_FFF0, 32'h0);
    req_chk(64'h0000_0000_7001_0020, "R9 memory kind carries fully");

    // random rounds
    for (int rnd = 0; rnd < 6; rnd++) begin
      for (int k = 0; k < NR; k++) begin
        logic [31:0] b, sz;
        logic [4:0] kd;
        b  = $urandom & 32'h7FFF_F000;
        sz = ($urandom % 32'h0002_0000) + 1;
        case ($urandom % 4)
          0: kd = 5'd0; 1: kd = 5'd2; 2: kd = 5'd4; default: kd = 5'd5;
        endcase
        prog(k, kd, ($urandom % 5) != 0, b, $urandom % 2, b + sz - 1, $urandom, $urandom);
      end
      for (int n = 0; n < 40; n++) begin
        int k;
        logic [31:0] lo;
        k = $urandom % NR;
        case ($urandom % 5)
          0: lo = m_blo[k];
          1: lo = m_last[k];
          2: lo = m_blo[k] - 1;
          3: lo = m_last[k] + 1;
          default: lo = m_blo[k] + ($urandom % (m_last[k] - m_blo[k] + 1));
        endcase
        req_chk({(($urandom % 8) == 0) ? ~m_bhi[k] : m_bhi[k], lo},
                "R6 R7 R8 R9 random request");
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule